// File: doc/BRIEF.md
# Four-Channel Periodic Countdown Timer

The block holds a bank of independent down-counters that a processor programs over a plain register bus. Each channel keeps a reload value, a live count, a small control field and an event bit. Once started, a channel subtracts one every clock. When its count is zero it sets its event bit, takes the reload value again and keeps going. A reload of L therefore repeats every L+1 clocks. Each channel can raise the shared interrupt line through its own interrupt-enable bit.

A channel other than the first can be linked to the channel below it. A linked channel steps only on the clocks where its neighbour wraps, so channels 0 and 1 together make a 64-bit count. A global halt bit freezes every channel at once.

The register bus carries no stream. It is a single-cycle strobe interface with no back-pressure: a write takes effect at the clock edge where it is presented. Read data appears on `bus_rdata_o` from the clock edge after the read strobe and holds until the next read.

Top module: `tick_bank`

## Requirements
- R1: After reset every reload, count, control, event and halt bit is zero, `irq_o` is low and `bus_rdata_o` is zero.
- R2: A 0-to-1 change of control bit 0 (run) copies the reload value into the count. While the channel runs, the count drops by one each clock. From zero it takes the reload value again, so a reload of L gives a period of L+1 clocks.
- R3: Event register bit 0 is set on the clock where a running channel wraps from zero, and writing 1 to that bit clears it. If a clear and a wrap fall on the same clock, the bit ends up set.
- R4: `irq_o` is high exactly while some channel has both its event bit and control bit 1 (interrupt enable) set.
- R5: Writing the reload register of a running channel leaves the count in progress untouched. The new value is used from the next wrap onward.
- R6: Writing run=1 to a channel that already runs does not reload the count. Clearing run freezes the count at its present value. A later 0-to-1 change restarts the count from the reload value.
- R7: Bit 1 of the module register at offset 0x000 is the global halt. While it is 1, no channel's count changes except through a restart. Read-back of this register returns only bit 1.
- R8: When control bit 2 (link) of channel n>0 is set, that channel steps only on clocks where channel n-1 wraps. The link bit of channel 0 has no effect on how it counts.
- R9: Channel n's registers sit at 0x100+16n, at +0x0 (reload), +0x4 (count), +0x8 (control, bits 2:0) and +0xC (event, bit 0). Reads of any other or misaligned offset return zero, writes to them change nothing, and writes to the count register are ignored.
- R10: Read data is the register value seen at the clock edge of the read strobe, presented from that edge onward. Control read-back returns bits 2:0 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe, one clock per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid from the edge after a read strobe |
| irq_o | output | 1 | OR of event AND interrupt-enable over all channels |

## Verification
The event bit has two sources that can meet on one clock: a channel wrapping sets it, and a software write of 1 clears it. The bench arms a channel with a reload of 3 and counts clocks from the enable edge. It places the clearing write exactly on the second wrap edge, after the first wrap has already set the bit. A later read must still see the bit set. A second clear on a clock without a wrap must then leave it cleared. Random runs add a wide spread of reload values and wait times, each checked against the L+1-period count formula.

// File: rtl/tick_bank_pkg.sv
package tick_bank_pkg;

  // Register slot inside one channel window (offset bits 3:2)
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTL    = 2'd2,
    REG_EVENT  = 2'd3
  } ch_reg_e;

  // Control field; run sits in bit 0, link in bit 2
  typedef struct packed {
    logic link;
    logic irq_en;
    logic run;
  } ctl_t;

  localparam int unsigned CH_BASE   = 32'h100;
  localparam int unsigned CH_STRIDE = 16;
  localparam int unsigned HALT_BIT  = 1;

endpackage

// File: rtl/tick_bank_decode.sv
module tick_bank_decode
  import tick_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_mod_o,
  output logic              hit_ch_o,
  output logic [IDX_W-1:0]  ch_idx_o,
  output ch_reg_e           reg_o
);

  localparam int unsigned SPAN = NUM_CH * CH_STRIDE;

  logic [ADDR_W-1:0] off;

  always_comb begin
    off       = addr_i - ADDR_W'(CH_BASE);
    hit_mod_o = (addr_i == '0);
    hit_ch_o  = (addr_i >= ADDR_W'(CH_BASE)) && (off < ADDR_W'(SPAN)) &&
                (off[1:0] == 2'b00);
    ch_idx_o  = off[4 +: IDX_W];
    reg_o     = ch_reg_e'(off[3:2]);
  end

endmodule

// File: rtl/tick_bank_channel.sv
module tick_bank_channel
  import tick_bank_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter bit          HAS_PREV = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             prev_wrap_i,
  input  logic             wr_reload_i,
  input  logic             wr_ctl_i,
  input  logic             wr_event_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output ctl_t             ctl_o,
  output logic             event_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] reload_q, cnt_q;
  ctl_t             ctl_q;
  logic             event_q;
  logic             gate_ok;
  logic             step;
  logic             restart;

  generate
    if (HAS_PREV) begin : g_linkable
      assign gate_ok = ctl_q.link ? prev_wrap_i : 1'b1;
    end else begin : g_first
      assign gate_ok = 1'b1;
    end
  endgenerate

  assign step    = ctl_q.run && !halt_i && gate_ok;
  assign wrap_o  = step && (cnt_q == '0);
  assign restart = wr_ctl_i && wdata_i[0] && !ctl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
      ctl_q    <= '0;
      event_q  <= 1'b0;
    end else begin
      if (wr_reload_i) reload_q <= wdata_i;
      if (wr_ctl_i)    ctl_q    <= ctl_t'(wdata_i[2:0]);
      if (restart || wrap_o) cnt_q <= reload_q;
      else if (step)         cnt_q <= cnt_q - 1'b1;
      if (wrap_o)                       event_q <= 1'b1;
      else if (wr_event_i && wdata_i[0]) event_q <= 1'b0;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = cnt_q;
  assign ctl_o    = ctl_q;
  assign event_o  = event_q;

  assert_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wr_ctl_i) |=> $stable(cnt_q));

  assert_wrap_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.run && !halt_i && gate_ok && cnt_q == '0) |=> (cnt_q == $past(reload_q)));

  assert_wrap_sets_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> event_q);

  generate
    if (HAS_PREV) begin : g_link_chk
      assert_link_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.link && !prev_wrap_i && !wr_ctl_i) |=> $stable(cnt_q));
    end
  endgenerate

endmodule

// File: rtl/tick_bank.sv
module tick_bank
  import tick_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic             hit_mod, hit_ch;
  logic [IDX_W-1:0] ch_idx;
  ch_reg_e          reg_sel;
  logic             halt_q;
  logic             wr_go, rd_go;
  logic [DATA_W-1:0] rd_next, rdata_q;

  logic [CNT_W-1:0] reload_v [NUM_CH];
  logic [CNT_W-1:0] count_v  [NUM_CH];
  ctl_t             ctl_v    [NUM_CH];
  logic [NUM_CH-1:0] event_v, wrap_v, ien_v;

  tick_bank_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i    (bus_addr_i),
    .hit_mod_o (hit_mod),
    .hit_ch_o  (hit_ch),
    .ch_idx_o  (ch_idx),
    .reg_o     (reg_sel)
  );

  assign wr_go = bus_sel_i && bus_wr_i;
  assign rd_go = bus_sel_i && !bus_wr_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_here;
      logic prev_wrap;
      assign sel_here = wr_go && hit_ch && (ch_idx == IDX_W'(c));
      if (c == 0) begin : g_head
        assign prev_wrap = 1'b0;
      end else begin : g_tail
        assign prev_wrap = wrap_v[c-1];
      end

      tick_bank_channel #(.CNT_W(CNT_W), .HAS_PREV(c > 0)) u_ch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .halt_i      (halt_q),
        .prev_wrap_i (prev_wrap),
        .wr_reload_i (sel_here && reg_sel == REG_RELOAD),
        .wr_ctl_i    (sel_here && reg_sel == REG_CTL),
        .wr_event_i  (sel_here && reg_sel == REG_EVENT),
        .wdata_i     (bus_wdata_i[CNT_W-1:0]),
        .reload_o    (reload_v[c]),
        .count_o     (count_v[c]),
        .ctl_o       (ctl_v[c]),
        .event_o     (event_v[c]),
        .wrap_o      (wrap_v[c])
      );
      assign ien_v[c] = ctl_v[c].irq_en;
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (hit_mod) begin
      rd_next[HALT_BIT] = halt_q;
    end else if (hit_ch) begin
      unique case (reg_sel)
        REG_RELOAD: rd_next = DATA_W'(reload_v[ch_idx]);
        REG_COUNT:  rd_next = DATA_W'(count_v[ch_idx]);
        REG_CTL:    rd_next = DATA_W'(ctl_v[ch_idx]);
        REG_EVENT:  rd_next = DATA_W'(event_v[ch_idx]);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_go && hit_mod) halt_q  <= bus_wdata_i[HALT_BIT];
      if (rd_go)            rdata_q <= rd_next;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = |(event_v & ien_v);

  assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|event_v));

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && !hit_mod && !hit_ch) |=> (bus_rdata_o == '0));

endmodule

// File: tb/tick_bank_test.sv
`timescale 1ns/1ps
module tick_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0, fails = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  tick_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq)
  );

  function automatic logic [11:0] ra(input int ch, input int slot);
    return 12'(32'h100 + ch * 16 + slot * 4);
  endfunction

  function automatic logic [31:0] exp_count(input int unsigned l, input int unsigned n);
    return 32'(l - (n % (l + 1)));
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(ra(2, 0), rv); chk("R1 reload", rv, 0);
    rd(ra(0, 2), rv); chk("R1 ctl", rv, 0);
    rd(12'h000, rv);  chk("R1 halt", rv, 0);

    // R2/R4 period L+1 seen on irq; ch0 reload 4, run+irq_en
    wr(ra(0, 0), 4);
    wr(ra(0, 2), 3);
    repeat (4) @(negedge clk);
    chk("R4 irq low before wrap", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R4 irq high at wrap", {31'b0, irq}, 1);
    rd(ra(0, 1), rv); chk("R2 reloaded count", rv, 4);
    wr(ra(0, 3), 1);
    chk("R3 clear drops irq", {31'b0, irq}, 0);

    // R3 collision: clear lands on wrap edge
    wr(ra(0, 2), 0);
    wr(ra(0, 0), 3);
    wr(ra(0, 2), 3);
    repeat (7) @(negedge clk);
    wr(ra(0, 3), 1);
    rd(ra(0, 3), rv); chk("R3 set wins over clear", rv, 1);
    wr(ra(0, 3), 1);
    rd(ra(0, 3), rv); chk("R3 clear off-wrap", rv, 0);

    // R5 reload write while running
    wr(ra(1, 0), 6);
    wr(ra(1, 2), 1);
    wr(ra(1, 0), 2);
    rd(ra(1, 1), rv); chk("R5 count unaffected", rv, 5);
    repeat (5) @(negedge clk);
    rd(ra(1, 1), rv); chk("R5 new reload after wrap", rv, 2);
    rd(ra(1, 0), rv); chk("R10 reload readback", rv, 2);

    // R6 rewrite run, stop, restart
    wr(ra(2, 0), 10);
    wr(ra(2, 2), 1);
    repeat (3) @(negedge clk);
    wr(ra(2, 2), 1);
    rd(ra(2, 1), rv); chk("R6 no reload on 1->1", rv, 6);
    wr(ra(2, 2), 0);
    rd(ra(2, 1), rv); chk("R6 frozen", rv, 4);
    repeat (3) @(negedge clk);
    rd(ra(2, 1), rv); chk("R6 still frozen", rv, 4);
    wr(ra(2, 2), 1);
    rd(ra(2, 1), rv); chk("R6 restart", rv, 10);

    // R7 global halt
    wr(12'h000, 32'h2);
    rd(ra(2, 1), rv); chk("R7 halted", rv, 8);
    repeat (4) @(negedge clk);
    rd(ra(2, 1), rv); chk("R7 stays halted", rv, 8);
    rd(12'h000, rv);  chk("R7 halt readback", rv, 2);
    wr(12'h000, 32'h0);
    rd(ra(2, 1), rv); chk("R7 resume first", rv, 8);
    rd(ra(2, 1), rv); chk("R7 resume step", rv, 7);

    // R8 linking ch1 to ch0
    wr(ra(0, 2), 0);
    wr(ra(1, 2), 0);
    wr(ra(0, 0), 2);
    wr(ra(1, 0), 5);
    wr(ra(1, 2), 5);
    repeat (4) @(negedge clk);
    rd(ra(1, 1), rv); chk("R8 idle without neighbour wrap", rv, 5);
    wr(ra(0, 2), 1);
    repeat (7) @(negedge clk);
    rd(ra(1, 1), rv); chk("R8 steps per neighbour wrap", rv, 3);
    wr(ra(0, 2), 0);
    wr(ra(1, 2), 0);
    wr(ra(0, 0), 4);
    wr(ra(0, 2), 5);
    repeat (2) @(negedge clk);
    rd(ra(0, 1), rv); chk("R8 link ignored on ch0", rv, 2);
    rd(ra(0, 2), rv); chk("R10 ctl readback", rv, 5);

    // R9 map corners
    rd(12'h040, rv); chk("R9 unmapped read", rv, 0);
    rd(12'h101, rv); chk("R9 misaligned read", rv, 0);
    wr(12'h140, 32'hFFFF_FFFF);
    rd(ra(3, 2), rv); chk("R9 out-of-range write ignored", rv, 0);
    wr(ra(3, 1), 32'h55);
    rd(ra(3, 1), rv); chk("R9 count write ignored", rv, 0);
    wr(12'h102, 32'h77);
    rd(ra(0, 0), rv); chk("R9 misaligned write ignored", rv, 4);
    wr(12'h000, 32'hFFFF_FFFD);
    rd(12'h000, rv); chk("R7 only halt bit kept", rv, 0);

    // R2 random periods
    void'($urandom(32'd1357));
    for (int it = 0; it < 24; it++) begin
      int unsigned ch, l, n;
      ch = $urandom % 4;
      l  = 1 + ($urandom % 20);
      n  = $urandom % 40;
      wr(ra(int'(ch), 2), 0);
      wr(ra(int'(ch), 0), l);
      wr(ra(int'(ch), 2), 1);
      repeat (n) @(negedge clk);
      rd(ra(int'(ch), 1), rv);
      chk("R2 random period", rv, exp_count(l, n));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule